// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Strobe Controller

This block sits between an internal request bus and an external asynchronous static RAM with an 18-bit word address, a 16-bit shared data bus and two byte-lane enables. It accepts one word request at a time over a valid/ready handshake. Each request carries an address, write data, a read/write flag and a two-bit lane mask. The block turns the request into a sequence of active-low chip enable, write enable, output enable and lane enable levels. It also decides when the block itself drives the shared data bus.

Every phase length is computed at elaboration time from a clock period and a set of nanosecond timing values, all given as parameters. Each phase lasts the ceiling of the time divided by the clock period, and never less than one cycle. A read returns a word with a one-cycle valid pulse. A write returns a one-cycle done pulse. All strobes are registered, so they change only on clock edges. The address moves only while every strobe is inactive.

Top module: `sramc_top`

## Requirements
- R1: A read holds chip enable and output enable low, with write enable high, for RD_CYC consecutive cycles. RD_CYC is the largest of ceil(T_AA/CLK), ceil(T_OE/CLK) and ceil(T_RC/CLK)-1, and at least 1. The defaults (CLK 4 ns, T_AA 10, T_OE 5, T_RC 10) give 3.
- R2: `req_ready` is high only while the controller is idle and out of reset. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` stays low until that request has finished.
- R3: Each request starts with one setup cycle. In that cycle `mem_addr` already shows the new address and all strobes are high. `mem_addr` never changes on an edge unless chip enable, write enable and both lane enables are high on both sides of that edge.
- R4: A write holds chip enable and write enable low for WR_CYC consecutive cycles. WR_CYC is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK), ceil(T_DW/CLK)+1 and ceil(T_WC/CLK)-1; the defaults give 3. Output enable stays high during every write.
- R5: `mem_dq_oe` is high only while write enable is low, and never in the first cycle of the write phase. It therefore presents `req_wdata` for WR_CYC-1 cycles before write enable rises. It falls with write enable. Output enable is never low in the cycle right after one in which `mem_dq_oe` was high.
- R6: Mask bit 0 selects the lower lane (data bits 7:0, `mem_lb_n`) and mask bit 1 selects the upper lane (bits 15:8, `mem_ub_n`); a set bit enables the lane. A lane enable is low only in cycles where chip enable is low and its mask bit is set.
- R7: Read data is captured at the end of the last read cycle. `rsp_rvalid` is high for exactly the one cycle after it, with `rsp_rdata` holding the captured word. A lane whose mask bit is clear reads as zero.
- R8: In the cycle after write enable rises, `rsp_wdone` is high for one cycle and `req_ready` is still low. `req_ready` returns in the following cycle.
- R9: A write changes only the lanes whose mask bit is set. A write with mask 00 leaves the stored word unchanged.
- R10: While reset is high, all strobes are high, `mem_dq_oe`, `rsp_rvalid` and `rsp_wdone` are low, and `req_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_rvalid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| rsp_wdone | output | 1 | One-cycle write completion |
| mem_addr | output | ADDR_W | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_dq_out | output | 16 | Value for the data bus when driven |
| mem_dq_oe | output | 1 | Data bus driver enable, high = controller drives |
| mem_dq_in | input | 16 | Value seen on the data bus |

## Verification
The bench measures every strobe phase cycle by cycle at the pins. A phase that is one cycle too short or too long shows up as a wrong count against the nanosecond-derived length. A RAM model that puts junk on disabled or floating lanes exposes a controller that forgets to zero masked lanes. The model stores the complement of the data when a write ends with the bus released, so a driver that drops early or starts late corrupts readback. Partial-mask and zero-mask writes followed by full reads catch lane enables that are swapped or ignore the mask. Back-to-back write-then-read pairs at the lowest and highest addresses catch bus contention and address changes made while strobes are still active.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    localparam int unsigned DATA_W = 16;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_READ,
        ST_WRITE,
        ST_RECOV
    } sramc_state_e;

    typedef struct packed {
        logic             ce_n;
        logic             we_n;
        logic             oe_n;
        logic [LANES-1:0] lane_n;
        logic             dq_oe;
    } sramc_strobe_t;

    localparam sramc_strobe_t STROBE_OFF = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1,
                                             lane_n: '1, dq_oe: 1'b0};

    // cycles covering t_ns at clk_ns, never below one
    function automatic int unsigned ns2cyc(int unsigned t_ns, int unsigned clk_ns);
        int unsigned c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned less1(int unsigned a);
        return (a > 1) ? a - 1 : 1;
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/sramc_lane.sv
module sramc_lane #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         active,
    input  logic         capture,
    input  logic [W-1:0] dq_in,
    output logic         lane_n_d,
    output logic [W-1:0] rdata
);
    assign lane_n_d = !(en && active);

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (capture)
            rdata <= en ? dq_in : '0;
    end
endmodule

// File: rtl/sramc_top.sv
module sramc_top
    import sramc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 18,
    parameter int unsigned CLK_NS  = 4,
    parameter int unsigned T_RC_NS = 10,
    parameter int unsigned T_AA_NS = 10,
    parameter int unsigned T_OE_NS = 5,
    parameter int unsigned T_WC_NS = 10,
    parameter int unsigned T_WP_NS = 8,
    parameter int unsigned T_AW_NS = 8,
    parameter int unsigned T_DW_NS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    output logic              rsp_rvalid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_wdone,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned RD_CYC = max2(max2(ns2cyc(T_AA_NS, CLK_NS), ns2cyc(T_OE_NS, CLK_NS)),
                                          less1(ns2cyc(T_RC_NS, CLK_NS)));
    localparam int unsigned WR_CYC = max2(max2(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                          max2(ns2cyc(T_DW_NS, CLK_NS) + 1,
                                               less1(ns2cyc(T_WC_NS, CLK_NS))));
    localparam int unsigned CNT_W  = $clog2(max2(RD_CYC, WR_CYC) + 1);

    sramc_state_e      st, st_n;
    sramc_strobe_t     strb_q, strb_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              wr_q;
    logic              rvalid_q, wdone_q;
    logic              phase_done, load_timer, active_n, capture;
    logic [CNT_W-1:0]  load_val;
    logic [LANES-1:0]  lane_n_d;

    assign load_timer = (st == ST_SETUP);
    assign load_val   = wr_q ? CNT_W'(WR_CYC - 1) : CNT_W'(RD_CYC - 1);
    assign capture    = (st == ST_READ) && phase_done;

    sramc_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_timer),
        .load_val (load_val),
        .done     (phase_done)
    );

    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE:  if (req_valid) st_n = ST_SETUP;
            ST_SETUP: st_n = wr_q ? ST_WRITE : ST_READ;
            ST_READ:  if (phase_done) st_n = ST_IDLE;
            ST_WRITE: if (phase_done) st_n = ST_RECOV;
            ST_RECOV: st_n = ST_IDLE;
            default:  st_n = ST_IDLE;
        endcase
    end

    assign active_n = (st_n == ST_READ) || (st_n == ST_WRITE);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sramc_lane #(.W(LANE_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .en       (mask_q[g]),
            .active   (active_n),
            .capture  (capture),
            .dq_in    (mem_dq_in[g*LANE_W +: LANE_W]),
            .lane_n_d (lane_n_d[g]),
            .rdata    (rsp_rdata[g*LANE_W +: LANE_W])
        );
    end

    always_comb begin
        strb_d        = STROBE_OFF;
        strb_d.ce_n   = !active_n;
        strb_d.we_n   = !(st_n == ST_WRITE);
        strb_d.oe_n   = !(st_n == ST_READ);
        strb_d.lane_n = lane_n_d;
        strb_d.dq_oe  = (st_n == ST_WRITE) && (st == ST_WRITE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            strb_q   <= STROBE_OFF;
            addr_q   <= '0;
            wdata_q  <= '0;
            mask_q   <= '0;
            wr_q     <= 1'b0;
            rvalid_q <= 1'b0;
            wdone_q  <= 1'b0;
        end else begin
            st       <= st_n;
            strb_q   <= strb_d;
            rvalid_q <= capture;
            wdone_q  <= (st == ST_WRITE) && phase_done;
            if (st == ST_IDLE && req_valid) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
                wr_q    <= req_write;
            end
        end
    end

    assign req_ready  = (st == ST_IDLE) && !rst;
    assign rsp_rvalid = rvalid_q;
    assign rsp_wdone  = wdone_q;
    assign mem_addr   = addr_q;
    assign mem_ce_n   = strb_q.ce_n;
    assign mem_we_n   = strb_q.we_n;
    assign mem_oe_n   = strb_q.oe_n;
    assign mem_lb_n   = strb_q.lane_n[0];
    assign mem_ub_n   = strb_q.lane_n[1];
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = strb_q.dq_oe;
endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned WR_CYC = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_rvalid,
    input logic              rsp_wdone,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic              mem_dq_oe
);
    logic [7:0] we_low_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            we_low_cnt <= '0;
        else if (!mem_we_n)
            we_low_cnt <= we_low_cnt + 8'd1;
        else
            we_low_cnt <= '0;
    end

    a_r3_addr_moves_idle: assert property (@(posedge clk) disable iff (rst)
        (mem_addr != $past(mem_addr)) |->
            (mem_ce_n && mem_we_n && mem_lb_n && mem_ub_n &&
             $past(mem_ce_n) && $past(mem_we_n) && $past(mem_lb_n) && $past(mem_ub_n)));

    a_r4_oe_high_in_write: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    a_r4_write_pulse_len: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt == 8'(WR_CYC)));

    a_r5_drive_only_in_write: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    a_r5_release_before_oe: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> !$past(mem_dq_oe));

    a_r6_lane_needs_ce: assert property (@(posedge clk) disable iff (rst)
        (!mem_lb_n || !mem_ub_n) |-> !mem_ce_n);

    a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (mem_ce_n && !mem_dq_oe));

    a_r7_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_rvalid |=> !rsp_rvalid);

    a_r8_wdone_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_wdone |=> (!rsp_wdone && req_ready));
endmodule

bind sramc_top sramc_chk #(.ADDR_W(ADDR_W), .WR_CYC(WR_CYC)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_rvalid (rsp_rvalid),
    .rsp_wdone  (rsp_wdone),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_lb_n   (mem_lb_n),
    .mem_ub_n   (mem_ub_n),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sramc_top.sv
`timescale 1ns/1ps
module tb_sramc_top;
    localparam int AW = 18;

    function automatic int cdiv(int t, int c);
        int r;
        r = (t + c - 1) / c;
        return (r < 1) ? 1 : r;
    endfunction
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // expected phase lengths from the default timing values (clock 4 ns)
    localparam int EXP_RD = imax(imax(cdiv(10, 4), cdiv(5, 4)), cdiv(10, 4) - 1);
    localparam int EXP_WR = imax(imax(cdiv(8, 4), cdiv(8, 4)), imax(cdiv(6, 4) + 1, cdiv(10, 4) - 1));

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_mask = '0;
    logic          rsp_rvalid, rsp_wdone;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0]   mem_dq_out, mem_dq_in;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sramc_top dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_rvalid(rsp_rvalid), .rsp_rdata(rsp_rdata), .rsp_wdone(rsp_wdone),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // RAM model: floating or disabled lanes read as junk
    logic [15:0] ram [int];
    logic [15:0] golden [int];
    logic        pend = 1'b0;
    logic        pend_oe = 1'b0;
    logic [1:0]  pend_lanes = '0;
    logic [15:0] pend_data = '0;
    int          pend_addr = 0;

    always_comb begin
        logic [15:0] w;
        w = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0000;
        mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? w[7:0]  : 8'hA5;
        mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? w[15:8] : 8'h5A;
    end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_we_n) begin
            pend       = 1'b1;
            pend_oe    = mem_dq_oe;
            pend_data  = mem_dq_out;
            pend_lanes = {!mem_ub_n, !mem_lb_n};
            pend_addr  = int'(mem_addr);
        end else if (pend) begin
            logic [15:0] w, d;
            w = ram.exists(pend_addr) ? ram[pend_addr] : 16'h0000;
            d = pend_oe ? pend_data : ~pend_data;
            if (pend_lanes[0]) w[7:0]  = d[7:0];
            if (pend_lanes[1]) w[15:8] = d[15:8];
            ram[pend_addr] = w;
            pend = 1'b0;
        end
    end

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] lane_bits(logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    task automatic do_op(bit wr, logic [AW-1:0] a, logic [15:0] d, logic [1:0] m);
        int n;
        logic [15:0] g, e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        // setup cycle
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R3 setup strobes high", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1f);
        chk(mem_addr == a, "R3 address in setup", 32'(mem_addr), 32'(a));
        chk(!req_ready, "R2 busy in setup", 32'(req_ready), 0);
        n = 0;
        @(negedge clk);
        while (!mem_ce_n && n < 40) begin
            n++;
            chk({mem_ub_n, mem_lb_n} == ~m, "R6 lane enables", {mem_ub_n, mem_lb_n}, ~m);
            if (wr) begin
                chk(!mem_we_n && mem_oe_n, "R4 write strobes", {mem_we_n, mem_oe_n}, 2'b01);
                chk(mem_dq_oe == (n > 1), "R5 bus drive window", 32'(mem_dq_oe), 32'(n > 1));
                if (mem_dq_oe) chk(mem_dq_out == d, "R5 bus data", 32'(mem_dq_out), 32'(d));
            end else begin
                chk(mem_we_n && !mem_oe_n && !mem_dq_oe, "R1 read strobes",
                    {mem_we_n, mem_oe_n, mem_dq_oe}, 3'b100);
            end
            @(negedge clk);
        end
        g = golden.exists(int'(a)) ? golden[int'(a)] : 16'h0000;
        if (wr) begin
            chk(n == EXP_WR, "R4 write phase length", 32'(n), 32'(EXP_WR));
            chk(rsp_wdone && !req_ready && !mem_dq_oe, "R8 done in recovery",
                {rsp_wdone, req_ready, mem_dq_oe}, 3'b100);
            e = (g & ~lane_bits(m)) | (d & lane_bits(m));
            golden[int'(a)] = e;
            @(negedge clk);
            chk(!rsp_wdone && req_ready, "R8 done pulse ends, ready back",
                {rsp_wdone, req_ready}, 2'b01);
        end else begin
            chk(n == EXP_RD, "R1 read phase length", 32'(n), 32'(EXP_RD));
            e = g & lane_bits(m);
            chk(rsp_rvalid, "R7 read valid", 32'(rsp_rvalid), 1);
            chk(rsp_rdata == e, "R7 R9 read data", 32'(rsp_rdata), 32'(e));
            @(negedge clk);
            chk(!rsp_rvalid, "R7 valid one cycle", 32'(rsp_rvalid), 0);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
    end

    initial begin
        logic [AW-1:0] pool [8];
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n, "R10 strobes in reset",
            {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n}, 5'h1f);
        chk(!mem_dq_oe && !rsp_rvalid && !rsp_wdone && !req_ready, "R10 outputs in reset",
            {mem_dq_oe, rsp_rvalid, rsp_wdone, req_ready}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R2 ready after reset", 32'(req_ready), 1);

        // directed corners
        do_op(1, 18'h00000, 16'h1234, 2'b11);
        do_op(0, 18'h00000, 16'h0000, 2'b11);
        do_op(1, 18'h3FFFF, 16'hBEEF, 2'b11);
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1, 18'h3FFFF, 16'h77CC, 2'b01);   // lower lane only
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1, 18'h3FFFF, 16'h9911, 2'b10);   // upper lane only
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1, 18'h00000, 16'hFFFF, 2'b00);   // R9 no lane written
        do_op(0, 18'h00000, 16'h0000, 2'b11);
        do_op(0, 18'h3FFFF, 16'h0000, 2'b01);   // R7 upper masked to zero
        do_op(0, 18'h3FFFF, 16'h0000, 2'b10);   // R7 lower masked to zero
        do_op(0, 18'h3FFFF, 16'h0000, 2'b00);

        // random traffic over a small address pool
        for (int i = 0; i < 8; i++) pool[i] = AW'($urandom);
        for (int i = 0; i < 300; i++) begin
            do_op(1'($urandom), pool[$urandom % 8], 16'($urandom), 2'($urandom));
        end
        for (int i = 0; i < 8; i++) do_op(0, pool[i], 16'h0000, 2'b11);
        report();
    end
endmodule